// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block is the host side of an SMBus controller as software sees it: a small bank of byte registers holding a protocol selector, a status byte, the target address, a command byte, a 32-byte data buffer, a byte count and three alarm bytes. Software fills in the operands and then writes the protocol selector. That single write launches a complete SMBus transaction. The block walks through it one byte at a time on a byte-level bus master interface. Each request is a start, a repeated start, a stop, a byte write or a byte read. The bit engine behind that interface reports acknowledge and returns received bytes.

Received bytes are placed back in the data buffer, starting at data entry 0. A block read also stores the received count in the count register. When the sequence ends, the status byte shows a done flag and a five-bit result code. The PEC request bit of the protocol selector is kept in the register and has no other effect. Checksum generation, bit timing and alarm reception are the job of other blocks.

Top module: `smbus_txn_seq`

## Requirements
- R1: Register offsets are as follows: protocol 0x00, status 0x01, address 0x02, command 0x03, data entries 0 to 31 at 0x04 to 0x23, count 0x24, alarm bytes 0x25 to 0x27. Address, command, count, alarm and data registers read back what was written. The protocol register reads back the last value that launched a transaction. Writes to status are ignored. Offsets 0x28 and above read 0x00. All registers reset to 0x00.
- R2: The status register is laid out as follows: bit 7 is done, bits 6:5 read 0, and bits 4:0 hold the result code, where 0x00 means success. An accepted protocol write clears done and the code on the next cycle. Done is set, with the code, once the sequence has finished, which is after its stop request where one is issued. After reset the bus request output is low.
- R3: The byte sent for the address is address-register bits 7:1 followed by a direction bit: 0 for write, 1 for read. Bit 0 of the address register is not used. Protocol 0x02 is a quick write and sends start, the address with direction 0, then stop. Protocol 0x03 is a quick read and sends the same sequence with direction 1. Request codes on the bus operation output are: start 0, write 1, read 2, repeated start 3, stop 4.
- R4: Protocol 0x04 sends start, the address with direction 0, the command byte, then stop. Protocol 0x05 sends start, the address with direction 1, reads one byte into data entry 0, then sends stop.
- R5: Protocol 0x06 sends start, the address, the command, data entry 0, then stop. Protocols 0x07 and 0x09 send start, the address with direction 0, the command, a repeated start and the address with direction 1. They then read one byte (0x07) or two bytes (0x09) into data entries 0 and 1, low byte in entry 0. Protocol 0x08 writes data entries 0 and 1 after the command.
- R6: Protocol 0x0C (process call) writes the command and data entries 0 and 1. It then issues a repeated start and the address with direction 1, and reads two bytes back into entries 0 and 1.
- R7: Protocol 0x0A (block write) sends the command, then the count register clipped to 32, then that many data entries. Protocol 0x0B (block read) reads a count byte first, stores it in the count register, then reads that many bytes into the data entries. Protocol 0x0D combines a block write with a block read, joined by a repeated start.
- R8: Protocol 0x4B reads the number of bytes preloaded in the count register (clipped to 32), with no count byte on the bus. Protocol 0x4A writes that number of bytes after the command, with no count byte.
- R9: A missing acknowledge on either address byte makes the next request a stop and gives code 0x10. A missing acknowledge on a command, count or data byte gives code 0x11. No further bytes are transferred after either.
- R10: A protocol value whose bits 6:0 are none of 0x02 to 0x0D, 0x4A or 0x4B sets done with code 0x19 two cycles after the write. It makes no bus request.
- R11: If a block read receives a count byte greater than 32, the next request is a stop and the code is 0x07. No data bytes are read and the count register keeps its old value.
- R12: A protocol write while a transaction is in progress is ignored. The protocol register keeps its value and the running sequence continues unchanged.
- R13: The master-not-acknowledge output is high only on the last data-byte read of a transaction. It is low on a block count byte.
- R14: Bit 7 of the protocol value (checksum request) is stored and read back. It does not change the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational on regAddr |
| busReq | output | 1 | Byte-level request pending, held until busDone |
| busOp | output | 3 | Request kind: 0 start, 1 write, 2 read, 3 repeated start, 4 stop |
| busTxByte | output | 8 | Byte to send for a write request |
| busNack | output | 1 | Master answers the read byte with not-acknowledge |
| busDone | input | 1 | One-cycle completion of the pending request |
| busAck | input | 1 | Slave acknowledged the written byte, valid with busDone |
| busRxByte | input | 8 | Byte received by a read request, valid with busDone |

## Verification
A wrong sequencer state shows up at the bus interface within one request. An extra, missing or misordered request (for example a stop instead of a repeated start) is seen as soon as the bit engine accepts it. A wrong buffer index or length shows either as a wrong transmitted byte or as a misplaced not-acknowledge on the final read. It can also show as a data or count register that differs when read back right after done. Error handling is visible two ways: in which request follows a refused byte, and in the result code present as soon as done rises.

// File: rtl/smb_seq_pkg.sv
`timescale 1ns/1ps
package smb_seq_pkg;
  localparam int BYTE_W     = 8;
  localparam int DATA_BYTES = 32;
  localparam int IDX_W      = $clog2(DATA_BYTES);
  localparam int LEN_W      = IDX_W + 1;
  localparam int REG_AW     = 6;
  localparam int ALARM_N    = 3;

  localparam logic [REG_AW-1:0] A_PROTO  = 6'h00;
  localparam logic [REG_AW-1:0] A_STATUS = 6'h01;
  localparam logic [REG_AW-1:0] A_ADDR   = 6'h02;
  localparam logic [REG_AW-1:0] A_CMD    = 6'h03;
  localparam int                DATA_BASE = 4;
  localparam logic [REG_AW-1:0] A_COUNT  = 6'h24;
  localparam int                ALARM_BASE = 37;

  localparam logic [4:0] RC_OK    = 5'h00;
  localparam logic [4:0] RC_FAIL  = 5'h07;
  localparam logic [4:0] RC_ANAK  = 5'h10;
  localparam logic [4:0] RC_DNAK  = 5'h11;
  localparam logic [4:0] RC_UNSUP = 5'h19;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_WRITE   = 3'd1,
    OP_READ    = 3'd2,
    OP_RESTART = 3'd3,
    OP_STOP    = 3'd4
  } busop_e;

  typedef struct packed {
    logic             firstRd;
    logic             sendCmd;
    logic             sendCnt;
    logic             doRead;
    logic             readCnt;
    logic [LEN_W-1:0] wrLen;
    logic [LEN_W-1:0] rdLen;
  } seqPlan_t;

  typedef struct packed {
    logic              doneSet;
    logic [4:0]        code;
    logic              dataWe;
    logic              cntWe;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] rxByte;
  } seqCtl_t;

  function automatic logic [LEN_W-1:0] clipCount(input logic [BYTE_W-1:0] c);
    if (c > BYTE_W'(DATA_BYTES)) return LEN_W'(DATA_BYTES);
    return c[LEN_W-1:0];
  endfunction

  function automatic logic protoOk(input logic [6:0] p);
    case (p)
      7'h02, 7'h03, 7'h04, 7'h05, 7'h06, 7'h07, 7'h08,
      7'h09, 7'h0A, 7'h0B, 7'h0C, 7'h0D, 7'h4A, 7'h4B: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic seqPlan_t planFor(input logic [6:0] p, input logic [BYTE_W-1:0] cnt);
    seqPlan_t r;
    logic [LEN_W-1:0] c;
    c = clipCount(cnt);
    r = '0;
    case (p)
      7'h03: r.firstRd = 1'b1;
      7'h04: r.sendCmd = 1'b1;
      7'h05: begin r.firstRd = 1'b1; r.doRead = 1'b1; r.rdLen = LEN_W'(1); end
      7'h06: begin r.sendCmd = 1'b1; r.wrLen = LEN_W'(1); end
      7'h07: begin r.sendCmd = 1'b1; r.doRead = 1'b1; r.rdLen = LEN_W'(1); end
      7'h08: begin r.sendCmd = 1'b1; r.wrLen = LEN_W'(2); end
      7'h09: begin r.sendCmd = 1'b1; r.doRead = 1'b1; r.rdLen = LEN_W'(2); end
      7'h0A: begin r.sendCmd = 1'b1; r.sendCnt = 1'b1; r.wrLen = c; end
      7'h0B: begin r.sendCmd = 1'b1; r.doRead = 1'b1; r.readCnt = 1'b1; end
      7'h0C: begin r.sendCmd = 1'b1; r.wrLen = LEN_W'(2); r.doRead = 1'b1; r.rdLen = LEN_W'(2); end
      7'h0D: begin r.sendCmd = 1'b1; r.sendCnt = 1'b1; r.wrLen = c; r.doRead = 1'b1; r.readCnt = 1'b1; end
      7'h4A: begin r.sendCmd = 1'b1; r.wrLen = c; end
      7'h4B: begin r.sendCmd = 1'b1; r.doRead = 1'b1; r.rdLen = c; end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/smb_regbank.sv
`timescale 1ns/1ps
module smb_regbank
  import smb_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              seqBusy,
  input  seqCtl_t           ctl,
  output logic              launch,
  output logic [6:0]        addrHi,
  output logic [BYTE_W-1:0] cmdQ,
  output logic [BYTE_W-1:0] cntQ,
  output logic [BYTE_W-1:0] dataAtIdx
);
  logic [BYTE_W-1:0] protoQ;
  logic [BYTE_W-1:0] addrQ;
  logic              doneQ;
  logic [4:0]        codeQ;
  logic [BYTE_W-1:0] dataMem  [DATA_BYTES];
  logic [BYTE_W-1:0] alarmMem [ALARM_N];

  assign launch    = regWe && (regAddr == A_PROTO) && !seqBusy;
  assign addrHi    = addrQ[7:1];
  assign dataAtIdx = dataMem[ctl.idx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoQ <= '0; addrQ <= '0; cmdQ <= '0; cntQ <= '0;
      doneQ  <= 1'b0; codeQ <= '0;
    end else begin
      if (launch) begin
        protoQ <= regWdata;
        doneQ  <= 1'b0;
        codeQ  <= RC_OK;
      end else if (ctl.doneSet) begin
        doneQ <= 1'b1;
        codeQ <= ctl.code;
      end
      if (regWe && regAddr == A_ADDR)  addrQ <= regWdata;
      if (regWe && regAddr == A_CMD)   cmdQ  <= regWdata;
      if (ctl.cntWe)                   cntQ  <= ctl.rxByte;
      else if (regWe && regAddr == A_COUNT) cntQ <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (!rstN) dataMem[i] <= '0;
      else if (ctl.dataWe && ctl.idx == IDX_W'(i)) dataMem[i] <= ctl.rxByte;
      else if (regWe && regAddr == REG_AW'(DATA_BASE + i)) dataMem[i] <= regWdata;
    end
    for (int j = 0; j < ALARM_N; j++) begin
      if (!rstN) alarmMem[j] <= '0;
      else if (regWe && regAddr == REG_AW'(ALARM_BASE + j)) alarmMem[j] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_PROTO:  regRdata = protoQ;
      A_STATUS: regRdata = {doneQ, 2'b00, codeQ};
      A_ADDR:   regRdata = addrQ;
      A_CMD:    regRdata = cmdQ;
      A_COUNT:  regRdata = cntQ;
      default:  ;
    endcase
    for (int i = 0; i < DATA_BYTES; i++)
      if (regAddr == REG_AW'(DATA_BASE + i)) regRdata = dataMem[i];
    for (int j = 0; j < ALARM_N; j++)
      if (regAddr == REG_AW'(ALARM_BASE + j)) regRdata = alarmMem[j];
  end

  // R2: an accepted launch leaves done and code clear on the next cycle
  assert_launch_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> (!doneQ && codeQ == RC_OK));

  // R12: protocol writes during a running sequence leave the register untouched
  assert_busy_proto_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_PROTO && seqBusy) |=> protoQ == $past(protoQ));
endmodule

// File: rtl/smb_seq_ctrl.sv
`timescale 1ns/1ps
module smb_seq_ctrl
  import smb_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              launch,
  input  logic [6:0]        launchProto,
  input  logic [6:0]        addrHi,
  input  logic [BYTE_W-1:0] cmdQ,
  input  logic [BYTE_W-1:0] cntQ,
  input  logic [BYTE_W-1:0] dataAtIdx,
  output logic              seqBusy,
  output seqCtl_t           ctl,
  output logic              busReq,
  output logic [2:0]        busOp,
  output logic [BYTE_W-1:0] busTxByte,
  output logic              busNack,
  input  logic              busDone,
  input  logic              busAck,
  input  logic [BYTE_W-1:0] busRxByte
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_WCNT, S_WDATA,
    S_RSTART, S_RADDR, S_RCNT, S_RDATA, S_STOP, S_DONE
  } state_e;

  state_e           state;
  seqPlan_t         plan;
  logic [IDX_W-1:0] idx;
  logic [4:0]       errCode;

  state_e afterWr, wrEntry, cmdNext, rdEntry;
  logic   lastWr, lastRd, rxTooBig;

  always_comb begin
    afterWr  = plan.doRead ? S_RSTART : S_STOP;
    wrEntry  = (plan.wrLen != '0) ? S_WDATA : afterWr;
    cmdNext  = plan.sendCnt ? S_WCNT : wrEntry;
    rdEntry  = plan.readCnt ? S_RCNT : ((plan.rdLen != '0) ? S_RDATA : S_STOP);
    lastWr   = ({1'b0, idx} == plan.wrLen - LEN_W'(1));
    lastRd   = ({1'b0, idx} == plan.rdLen - LEN_W'(1));
    rxTooBig = busRxByte > BYTE_W'(DATA_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; plan <= '0; idx <= '0; errCode <= RC_OK;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          plan    <= planFor(launchProto, cntQ);
          idx     <= '0;
          errCode <= protoOk(launchProto) ? RC_OK : RC_UNSUP;
          state   <= protoOk(launchProto) ? S_START : S_DONE;
        end
        S_START: if (busDone) state <= S_ADDR;
        S_ADDR: if (busDone) begin
          if (!busAck) begin errCode <= RC_ANAK; state <= S_STOP; end
          else if (plan.firstRd) state <= plan.doRead ? S_RDATA : S_STOP;
          else state <= plan.sendCmd ? S_CMD : cmdNext;
        end
        S_CMD: if (busDone) begin
          if (!busAck) begin errCode <= RC_DNAK; state <= S_STOP; end
          else state <= cmdNext;
        end
        S_WCNT: if (busDone) begin
          if (!busAck) begin errCode <= RC_DNAK; state <= S_STOP; end
          else state <= wrEntry;
        end
        S_WDATA: if (busDone) begin
          if (!busAck) begin errCode <= RC_DNAK; state <= S_STOP; end
          else if (lastWr) begin idx <= '0; state <= afterWr; end
          else idx <= idx + 1'b1;
        end
        S_RSTART: if (busDone) state <= S_RADDR;
        S_RADDR: if (busDone) begin
          if (!busAck) begin errCode <= RC_ANAK; state <= S_STOP; end
          else state <= rdEntry;
        end
        S_RCNT: if (busDone) begin
          if (rxTooBig) begin errCode <= RC_FAIL; state <= S_STOP; end
          else begin
            plan.rdLen <= busRxByte[LEN_W-1:0];
            idx        <= '0;
            state      <= (busRxByte == '0) ? S_STOP : S_RDATA;
          end
        end
        S_RDATA: if (busDone) begin
          if (lastRd) state <= S_STOP;
          else idx <= idx + 1'b1;
        end
        S_STOP: if (busDone) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busReq    = 1'b1;
    busOp     = OP_WRITE;
    busTxByte = '0;
    busNack   = 1'b0;
    case (state)
      S_START:  busOp = OP_START;
      S_ADDR:   busTxByte = {addrHi, plan.firstRd};
      S_CMD:    busTxByte = cmdQ;
      S_WCNT:   busTxByte = BYTE_W'(plan.wrLen);
      S_WDATA:  busTxByte = dataAtIdx;
      S_RSTART: busOp = OP_RESTART;
      S_RADDR:  busTxByte = {addrHi, 1'b1};
      S_RCNT:   busOp = OP_READ;
      S_RDATA:  begin busOp = OP_READ; busNack = lastRd; end
      S_STOP:   busOp = OP_STOP;
      default:  begin busReq = 1'b0; busOp = OP_START; end
    endcase
  end

  assign seqBusy     = (state != S_IDLE);
  assign ctl.doneSet = (state == S_DONE);
  assign ctl.code    = errCode;
  assign ctl.dataWe  = (state == S_RDATA) && busDone;
  assign ctl.cntWe   = (state == S_RCNT) && busDone && !rxTooBig;
  assign ctl.idx     = idx;
  assign ctl.rxByte  = busRxByte;

  // R3: a pending request keeps its kind until the engine completes it
  assert_op_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> (busReq && busOp == $past(busOp)));

  // R9: a refused address byte is followed directly by a stop request
  assert_anak_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_ADDR || state == S_RADDR) && busDone && !busAck)
      |=> (busReq && busOp == OP_STOP));

  // R10: an unsupported launch never reaches the bus
  assert_unsup_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (launch && !seqBusy && !protoOk(launchProto)) |=> (!busReq && ctl.doneSet));

  // R2: completion is only reported with the bus interface idle
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doneSet |-> !busReq);
endmodule

// File: rtl/smbus_txn_seq.sv
`timescale 1ns/1ps
module smbus_txn_seq
  import smb_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [5:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        busReq,
  output logic [2:0]  busOp,
  output logic [7:0]  busTxByte,
  output logic        busNack,
  input  logic        busDone,
  input  logic        busAck,
  input  logic [7:0]  busRxByte
);
  seqCtl_t           ctl;
  logic              launch, seqBusy;
  logic [6:0]        addrHi;
  logic [BYTE_W-1:0] cmdQ, cntQ, dataAtIdx;

  smb_regbank u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .seqBusy(seqBusy), .ctl(ctl),
    .launch(launch), .addrHi(addrHi), .cmdQ(cmdQ), .cntQ(cntQ),
    .dataAtIdx(dataAtIdx)
  );

  smb_seq_ctrl u_ctl (
    .clk(clk), .rstN(rstN), .launch(launch), .launchProto(regWdata[6:0]),
    .addrHi(addrHi), .cmdQ(cmdQ), .cntQ(cntQ), .dataAtIdx(dataAtIdx),
    .seqBusy(seqBusy), .ctl(ctl), .busReq(busReq), .busOp(busOp),
    .busTxByte(busTxByte), .busNack(busNack), .busDone(busDone),
    .busAck(busAck), .busRxByte(busRxByte)
  );
endmodule

// File: tb/smbus_txn_seq_tb_top.sv
`timescale 1ns/1ps
module smbus_txn_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       busReq, busNack;
  logic [2:0] busOp;
  logic [7:0] busTxByte;
  logic       busDone = 1'b0, busAck = 1'b0;
  logic [7:0] busRxByte = '0;

  always #5 clk = ~clk;

  smbus_txn_seq dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq), .busOp(busOp),
    .busTxByte(busTxByte), .busNack(busNack), .busDone(busDone),
    .busAck(busAck), .busRxByte(busRxByte)
  );

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R0";
  int wrSeen = 0;
  int nackAt = 0;
  logic [19:0] expQ [$];   // {op, nack, tx, rx}
  logic [19:0] item;
  logic        ackV;
  logic [7:0]  rxV;

  // driver side: push expected bus requests
  task automatic expOp(input logic [2:0] op, input logic nk, input logic [7:0] tx, input logic [7:0] rx);
    expQ.push_back({op, nk, tx, rx});
  endtask
  task automatic expS();  expOp(3'd0, 1'b0, 8'h00, 8'h00); endtask
  task automatic expSr(); expOp(3'd3, 1'b0, 8'h00, 8'h00); endtask
  task automatic expP();  expOp(3'd4, 1'b0, 8'h00, 8'h00); endtask
  task automatic expW(input logic [7:0] b); expOp(3'd1, 1'b0, b, 8'h00); endtask
  task automatic expR(input logic nk, input logic [7:0] rx); expOp(3'd2, nk, 8'h00, rx); endtask

  // monitor side: model of the bit engine, pops and compares
  initial begin
    forever begin
      @(negedge clk);
      if (busReq) begin
        vectors++;
        ackV = 1'b1; rxV = 8'h00;
        if (busOp == 3'd0) wrSeen = 0;
        if (busOp == 3'd1) begin wrSeen++; ackV = (wrSeen != nackAt); end
        if (expQ.size() == 0) begin
          miscompares++;
          $display("FAIL %s unexpected request: actual op=%0d tx=%02h expected none", curReq, busOp, busTxByte);
        end else begin
          item = expQ.pop_front();
          rxV = item[7:0];
          if (busOp != item[19:17] || busNack != item[16] ||
              (busOp == 3'd1 && busTxByte != item[15:8])) begin
            miscompares++;
            $display("FAIL %s bus request: actual op=%0d nack=%0b tx=%02h expected op=%0d nack=%0b tx=%02h",
                     curReq, busOp, busNack, busTxByte, item[19:17], item[16], item[15:8]);
          end
        end
        repeat (2) @(negedge clk);
        busDone = 1'b1; busAck = ackV; busRxByte = rxV;
        @(negedge clk);
        busDone = 1'b0; busAck = 1'b0;
      end
    end
  end

  task automatic regWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readCheck(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    vectors++;
    if (regRdata !== exp) begin
      miscompares++;
      $display("FAIL %s reg %02h: actual=%02h expected=%02h", tag, a, regRdata, exp);
    end
  endtask

  task automatic waitDone(input logic [7:0] expStat, input string tag);
    bit seen;
    seen = 0;
    regAddr = 6'h01;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      #1;
      if (regRdata[7]) seen = 1;
    end
    vectors++;
    if (!seen || regRdata !== expStat) begin
      miscompares++;
      $display("FAIL %s status: actual=%02h expected=%02h", tag, regRdata, expStat);
    end
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL %s requests left: actual=%0d expected=0", tag, expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL %s watchdog: actual=hung expected=done", curReq);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state
    curReq = "R2";
    readCheck(6'h01, 8'h00, "R2");
    vectors++;
    if (busReq !== 1'b0) begin
      miscompares++;
      $display("FAIL R2 busReq after reset: actual=%0b expected=0", busReq);
    end

    // R1: register map
    curReq = "R1";
    readCheck(6'h00, 8'h00, "R1");
    regWrite(6'h02, 8'hA1); regWrite(6'h03, 8'h5C); regWrite(6'h24, 8'h07);
    regWrite(6'h25, 8'h12); regWrite(6'h26, 8'h34); regWrite(6'h27, 8'h56);
    regWrite(6'h04, 8'h9A); regWrite(6'h23, 8'hBC); regWrite(6'h01, 8'hFF);
    regWrite(6'h2C, 8'hEE);
    readCheck(6'h02, 8'hA1, "R1"); readCheck(6'h03, 8'h5C, "R1");
    readCheck(6'h24, 8'h07, "R1"); readCheck(6'h25, 8'h12, "R1");
    readCheck(6'h26, 8'h34, "R1"); readCheck(6'h27, 8'h56, "R1");
    readCheck(6'h04, 8'h9A, "R1"); readCheck(6'h23, 8'hBC, "R1");
    readCheck(6'h01, 8'h00, "R1"); readCheck(6'h2C, 8'h00, "R1");

    // R3: quick write / read, address bit 0 replaced
    curReq = "R3";
    expS(); expW(8'hA0); expP();
    regWrite(6'h00, 8'h02); waitDone(8'h80, "R3");
    expS(); expW(8'hA1); expP();
    regWrite(6'h00, 8'h03); waitDone(8'h80, "R3");

    // R4 R13: send byte, receive byte with final nack
    curReq = "R4";
    expS(); expW(8'hA0); expW(8'h5C); expP();
    regWrite(6'h00, 8'h04); waitDone(8'h80, "R4");
    expS(); expW(8'hA1); expR(1'b1, 8'h3E); expP();
    regWrite(6'h00, 8'h05); waitDone(8'h80, "R4");
    readCheck(6'h04, 8'h3E, "R4");

    // R5: word read with repeated start, byte data write
    curReq = "R5";
    expS(); expW(8'hA0); expW(8'h5C); expSr(); expW(8'hA1);
    expR(1'b0, 8'h34); expR(1'b1, 8'h12); expP();
    regWrite(6'h00, 8'h09); waitDone(8'h80, "R5");
    readCheck(6'h04, 8'h34, "R5"); readCheck(6'h05, 8'h12, "R5");
    regWrite(6'h04, 8'h77);
    expS(); expW(8'hA0); expW(8'h5C); expW(8'h77); expP();
    regWrite(6'h00, 8'h06); waitDone(8'h80, "R5");

    // R6 R14: process call with checksum request bit
    curReq = "R6";
    regWrite(6'h04, 8'h11); regWrite(6'h05, 8'h22);
    expS(); expW(8'hA0); expW(8'h5C); expW(8'h11); expW(8'h22); expSr(); expW(8'hA1);
    expR(1'b0, 8'hAA); expR(1'b1, 8'hBB); expP();
    regWrite(6'h00, 8'h8C); waitDone(8'h80, "R6");
    readCheck(6'h04, 8'hAA, "R6"); readCheck(6'h05, 8'hBB, "R6");
    readCheck(6'h00, 8'h8C, "R14");

    // R7: block write with count clipped to 32
    curReq = "R7";
    for (int i = 0; i < 32; i++) regWrite(6'(4 + i), 8'(i * 5 + 3));
    regWrite(6'h24, 8'd40);
    expS(); expW(8'hA0); expW(8'h5C); expW(8'h20);
    for (int i = 0; i < 32; i++) expW(8'(i * 5 + 3));
    expP();
    regWrite(6'h00, 8'h0A); waitDone(8'h80, "R7");

    // R7 R13: block read stores count, nack on final byte only
    expS(); expW(8'hA0); expW(8'h5C); expSr(); expW(8'hA1);
    expR(1'b0, 8'h03); expR(1'b0, 8'hD1); expR(1'b0, 8'hD2); expR(1'b1, 8'hD3); expP();
    regWrite(6'h00, 8'h0B); waitDone(8'h80, "R7");
    readCheck(6'h24, 8'h03, "R7"); readCheck(6'h04, 8'hD1, "R7");
    readCheck(6'h06, 8'hD3, "R13");

    // R8: raw block read with preloaded count
    curReq = "R8";
    regWrite(6'h24, 8'h02);
    expS(); expW(8'hA0); expW(8'h5C); expSr(); expW(8'hA1);
    expR(1'b0, 8'h61); expR(1'b1, 8'h62); expP();
    regWrite(6'h00, 8'h4B); waitDone(8'h80, "R8");
    readCheck(6'h04, 8'h61, "R8"); readCheck(6'h05, 8'h62, "R8");

    // R9: address refused, then command refused
    curReq = "R9";
    nackAt = 1;
    expS(); expW(8'hA0); expP();
    regWrite(6'h00, 8'h02); waitDone(8'h90, "R9");
    nackAt = 2;
    expS(); expW(8'hA0); expW(8'h5C); expP();
    regWrite(6'h00, 8'h06); waitDone(8'h91, "R9");
    nackAt = 0;

    // R10: unsupported protocol, done two cycles after the write
    curReq = "R10";
    regWrite(6'h00, 8'h0E);
    readCheck(6'h01, 8'h99, "R10");
    waitDone(8'h99, "R10");

    // R11: oversized block count
    curReq = "R11";
    regWrite(6'h24, 8'h05);
    expS(); expW(8'hA0); expW(8'h5C); expSr(); expW(8'hA1); expR(1'b0, 8'h28); expP();
    regWrite(6'h00, 8'h0B); waitDone(8'h87, "R11");
    readCheck(6'h24, 8'h05, "R11");

    // R12: protocol write while busy is ignored
    curReq = "R12";
    regWrite(6'h04, 8'h41); regWrite(6'h05, 8'h42);
    expS(); expW(8'hA0); expW(8'h5C); expW(8'h41); expW(8'h42); expP();
    regWrite(6'h00, 8'h08); regWrite(6'h00, 8'h02);
    waitDone(8'h80, "R12");
    readCheck(6'h00, 8'h08, "R12");

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule